// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block gives each side of a two-port shared memory an active-low interrupt line that is driven purely by ordinary accesses to two reserved words at the top of the address space. The topmost word belongs to the right side and the word just below it belongs to the left side. When one side writes into the word owned by the other side, the owner's interrupt goes low; when the owner reads its own word, the interrupt returns high. The message itself lives in the shared memory; this block only watches the access strobes and addresses of both sides.

Each side also presents a collision busy flag from the memory's arbiter. While a side's busy flag is active, that side can neither raise the other side's interrupt nor clear its own. All access strobes are sampled on the rising clock edge, and the interrupt outputs are registered, so an access seen at one edge shows on the interrupt line right after that edge. The mailbox addresses follow from the address-width parameter as all-ones and all-ones minus one.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset is applied, both l_irq_n and r_irq_n are high.
- R2: A left write (l_ce_n low, l_we_n low, l_busy_n high) to address all-ones drives r_irq_n low after that clock edge.
- R3: A right write (r_ce_n low, r_we_n low, r_busy_n high) to address all-ones minus one drives l_irq_n low after that clock edge.
- R4: An owner read (chip enable low, we_n high, oe_n low, busy_n high) of its own mailbox drives that side's interrupt high after the edge: right at all-ones, left at all-ones minus one.
- R5: A side reading the other side's mailbox leaves both interrupts unchanged.
- R6: A write to the peer's mailbox while the writing side's busy_n is low leaves the peer's interrupt unchanged.
- R7: An owner read of its own mailbox while its busy_n is low leaves its interrupt low.
- R8: When a set and a clear of the same interrupt fall in the same cycle, the interrupt ends up low.
- R9: Accesses to any other address, accesses with chip enable high, reads with oe_n high, and a side writing its own mailbox leave both interrupts unchanged.
- R10: Once low, an interrupt stays low through idle cycles until its owner clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write strobe, active low (high means read) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left address |
| l_busy_n | input | 1 | Left collision busy flag, active low |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write strobe, active low (high means read) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right address |
| r_busy_n | input | 1 | Right collision busy flag, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Stimulus covers cross writes that raise each interrupt, owner reads that clear them, and reads of the peer's word, which tell an owner-only clear from one that any reader could trigger. Busy-gated writes and reads separate a gate applied to the acting side from one applied to the wrong side or not at all. Accesses to the word just below the mailboxes, with the enable or output enable withheld, and self-writes tell a full address and strobe decode from a partial one, and a same-cycle set and clear shows which of the two wins.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  localparam int unsigned NPORT  = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;

  // Decoded mailbox events of one side in one cycle
  typedef struct packed {
    logic raise_peer;  // wrote the other side's mailbox
    logic drop_own;    // read its own mailbox
  } mbox_evt_t;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
  import mbox_irq_pkg::*;
#(
  parameter int unsigned   AW        = 12,
  parameter logic [AW-1:0] OWN_BOX   = '1,
  parameter logic [AW-1:0] PEER_BOX  = '1
) (
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          busy_n,
  input  logic [AW-1:0] addr,
  output mbox_evt_t     evt
);
  logic granted;
  logic wr_hit;
  logic rd_hit;

  always_comb begin
    // A side held off by the arbiter has no effect on the flags
    granted        = !ce_n && busy_n;
    wr_hit         = granted && !we_n;
    rd_hit         = granted && we_n && !oe_n;
    evt.raise_peer = wr_hit && (addr == PEER_BOX);
    evt.drop_own   = rd_hit && (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  // Set has priority over clear in the same cycle
  always_comb begin
    pend_en = set_req | clr_req;
    pend_d  = set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_irq_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy_n,
  output logic          l_irq_n,
  input  logic          r_ce_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy_n,
  output logic          r_irq_n
);
  localparam logic [AW-1:0] BOX_R = {AW{1'b1}};
  localparam logic [AW-1:0] BOX_L = {AW{1'b1}} - AW'(1);

  logic             core_rst_n;
  logic [NPORT-1:0] ce_n;
  logic [NPORT-1:0] we_n;
  logic [NPORT-1:0] oe_n;
  logic [NPORT-1:0] busy_n;
  logic [AW-1:0]    addr [NPORT];
  mbox_evt_t        evt  [NPORT];
  logic [NPORT-1:0] irq_n;

  mbox_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  always_comb begin
    ce_n[PORT_L]   = l_ce_n;
    we_n[PORT_L]   = l_we_n;
    oe_n[PORT_L]   = l_oe_n;
    busy_n[PORT_L] = l_busy_n;
    addr[PORT_L]   = l_addr;
    ce_n[PORT_R]   = r_ce_n;
    we_n[PORT_R]   = r_we_n;
    oe_n[PORT_R]   = r_oe_n;
    busy_n[PORT_R] = r_busy_n;
    addr[PORT_R]   = r_addr;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_side
    localparam logic [AW-1:0] OWN  = (p == PORT_R) ? BOX_R : BOX_L;
    localparam logic [AW-1:0] PEER = (p == PORT_R) ? BOX_L : BOX_R;

    mbox_port_decode #(
      .AW       (AW),
      .OWN_BOX  (OWN),
      .PEER_BOX (PEER)
    ) u_dec (
      .ce_n   (ce_n[p]),
      .we_n   (we_n[p]),
      .oe_n   (oe_n[p]),
      .busy_n (busy_n[p]),
      .addr   (addr[p]),
      .evt    (evt[p])
    );

    // This side's flag is raised by the other side and dropped by itself
    mbox_irq_flag u_flag (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .set_req (evt[NPORT-1-p].raise_peer),
      .clr_req (evt[p].drop_own),
      .irq_n   (irq_n[p])
    );
  end

  assign l_irq_n = irq_n[PORT_L];
  assign r_irq_n = irq_n[PORT_R];
endmodule

// File: rtl/mbox_irq_ctrl_chk.sv
module mbox_irq_ctrl_chk #(
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_ce_n,
  input logic          l_we_n,
  input logic          l_oe_n,
  input logic [AW-1:0] l_addr,
  input logic          l_busy_n,
  input logic          l_irq_n,
  input logic          r_ce_n,
  input logic          r_we_n,
  input logic          r_oe_n,
  input logic [AW-1:0] r_addr,
  input logic          r_busy_n,
  input logic          r_irq_n
);
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = {AW{1'b1}} - AW'(1);

  logic l_set_r, r_set_l, r_clr_r, l_clr_l;
  assign l_set_r = !l_ce_n && !l_we_n && l_busy_n && (l_addr == TOP);
  assign r_set_l = !r_ce_n && !r_we_n && r_busy_n && (r_addr == NEXT);
  assign r_clr_r = !r_ce_n && r_we_n && !r_oe_n && r_busy_n && (r_addr == TOP);
  assign l_clr_l = !l_ce_n && l_we_n && !l_oe_n && l_busy_n && (l_addr == NEXT);

  always @(posedge clk) begin
    if (!rst_n) AST_RST_IDLE: assert (l_irq_n && r_irq_n); // R1
  end

  AST_SET_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    l_set_r |=> !r_irq_n); // R2
  AST_SET_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    r_set_l |=> !l_irq_n); // R3
  AST_CLR_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (r_clr_r && !l_set_r) |=> r_irq_n); // R4
  AST_CLR_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (l_clr_l && !r_set_l) |=> l_irq_n); // R4
  AST_BUSY_NO_SET_R: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n && r_irq_n) |=> r_irq_n); // R6
  AST_BUSY_NO_SET_L: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n && l_irq_n) |=> l_irq_n); // R6
  AST_BUSY_NO_CLR_R: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n && !r_irq_n) |=> !r_irq_n); // R7
  AST_BUSY_NO_CLR_L: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n && !l_irq_n) |=> !l_irq_n); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (l_set_r && r_clr_r) |=> !r_irq_n); // R8
  AST_HOLD_R: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_irq_n && !r_clr_r) |=> !r_irq_n); // R10
  AST_HOLD_L: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_irq_n && !l_clr_l) |=> !l_irq_n); // R10
endmodule

bind mbox_irq_ctrl mbox_irq_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_mbox_irq_ctrl.sv
`timescale 1ns/1ps
module sim_mbox_irq_ctrl;
  localparam int AW = 12;
  localparam logic [AW-1:0] TOP  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT = {AW{1'b1}} - AW'(1);
  localparam logic [AW-1:0] LOWR = {AW{1'b1}} - AW'(2);

  logic clk = 1'b0;
  logic rst_n;
  logic l_ce_n, l_we_n, l_oe_n, l_busy_n, r_ce_n, r_we_n, r_oe_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;

  always #5 clk = ~clk;

  mbox_irq_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_busy_n(l_busy_n), .l_irq_n(l_irq_n),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_busy_n(r_busy_n), .r_irq_n(r_irq_n)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string tag      = "R1";
  bit    exp_l_pend = 0;
  bit    exp_r_pend = 0;

  // Reference: pending flags per side, updated from the sampled accesses
  always @(posedge clk or negedge rst_n) begin
    bit s_r, c_r, s_l, c_l;
    if (!rst_n) begin
      exp_l_pend <= 0;
      exp_r_pend <= 0;
    end else begin
      s_r = (l_ce_n == 0) && (l_we_n == 0) && l_busy_n && (l_addr == TOP);
      s_l = (r_ce_n == 0) && (r_we_n == 0) && r_busy_n && (r_addr == NEXT);
      c_r = (r_ce_n == 0) && r_we_n && (r_oe_n == 0) && r_busy_n && (r_addr == TOP);
      c_l = (l_ce_n == 0) && l_we_n && (l_oe_n == 0) && l_busy_n && (l_addr == NEXT);
      if (s_r) exp_r_pend <= 1; else if (c_r) exp_r_pend <= 0;
      if (s_l) exp_l_pend <= 1; else if (c_l) exp_l_pend <= 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (l_irq_n !== !exp_l_pend) begin
        n_fail++;
        $display("FAIL %s l_irq_n actual=%b expected=%b t=%0t", tag, l_irq_n, !exp_l_pend, $time);
      end
      n_checks++;
      if (r_irq_n !== !exp_r_pend) begin
        n_fail++;
        $display("FAIL %s r_irq_n actual=%b expected=%b t=%0t", tag, r_irq_n, !exp_r_pend, $time);
      end
    end
  end

  task automatic idle();
    l_ce_n = 1; l_we_n = 1; l_oe_n = 1; l_addr = '0; l_busy_n = 1;
    r_ce_n = 1; r_we_n = 1; r_oe_n = 1; r_addr = '0; r_busy_n = 1;
  endtask

  task automatic tick(input string t);
    tag = t;
    @(negedge clk);
    #1;
    idle();
  endtask

  task automatic lw(input logic [AW-1:0] a);
    l_ce_n = 0; l_we_n = 0; l_addr = a;
  endtask
  task automatic rw(input logic [AW-1:0] a);
    r_ce_n = 0; r_we_n = 0; r_addr = a;
  endtask
  task automatic lr(input logic [AW-1:0] a);
    l_ce_n = 0; l_we_n = 1; l_oe_n = 0; l_addr = a;
  endtask
  task automatic rr(input logic [AW-1:0] a);
    r_ce_n = 0; r_we_n = 1; r_oe_n = 0; r_addr = a;
  endtask

  initial begin
    rst_n = 1;
    idle();
    #2 rst_n = 0;
    repeat (3) tick("R1");
    #1 rst_n = 1;
    repeat (3) tick("R1");

    lw(TOP);              tick("R2");
    repeat (2)            tick("R10");
    lr(TOP);              tick("R5");
    rr(NEXT);             tick("R5");
    rw(NEXT);             tick("R3");
    repeat (2)            tick("R10");
    r_ce_n = 0; r_we_n = 1; r_oe_n = 1; r_addr = TOP; tick("R9");
    rr(TOP);              tick("R4");
    lr(NEXT);             tick("R4");
    tick("R10");

    lw(TOP); l_busy_n = 0; tick("R6");
    rw(NEXT); r_busy_n = 0; tick("R6");
    lw(TOP); l_busy_n = 0; r_busy_n = 0; rw(NEXT); tick("R6");

    lw(TOP); rw(NEXT);    tick("R2");
    rr(TOP); r_busy_n = 0; tick("R7");
    lr(NEXT); l_busy_n = 0; tick("R7");
    rr(TOP); l_busy_n = 0; tick("R7");
    rr(TOP);              tick("R4");
    lr(NEXT);             tick("R4");

    lw(TOP); rr(TOP);     tick("R8");
    lw(TOP); rr(TOP);     tick("R8");
    rw(NEXT); lr(NEXT);   tick("R8");
    rr(TOP); lr(NEXT);    tick("R4");

    lw(LOWR); rw(LOWR);   tick("R9");
    lw(NEXT);             tick("R9");
    rw(TOP);              tick("R9");
    l_ce_n = 1; l_we_n = 0; l_addr = TOP; tick("R9");
    r_ce_n = 1; r_we_n = 0; r_addr = NEXT; tick("R9");
    lw(TOP); rw(NEXT);    tick("R3");
    lr(LOWR); rr(LOWR);   tick("R9");
    lr(TOP); rr(NEXT);    tick("R5");
    rr(TOP); lr(NEXT);    tick("R4");
    tick("R10");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule